// File: doc/BRIEF.md
# Flash Sector-Erase Command Controller

This block is the command state machine of a parallel NOR flash for sector erase with suspend and resume. It watches bus write cycles (word address and data byte) and recognises a six-write erase sequence. The last write names the first sector to erase. An acceptance window then opens. While it is open, further single erase writes add more sectors, and each one restarts the window. When the window expires, an abstracted erase phase runs for a set number of clock cycles. At the end, every selected sector reads as erased and the selection is released.

During the window and the erase phase, every read returns a status byte instead of array data. The status byte carries a toggle bit and an erase-timer bit. A suspend command behaves differently by phase. In the window it takes effect at once. During the erase it takes effect after a fixed latency. While suspended, reads of selected sectors return a suspend status byte, reads of other sectors return array data, and a resume command continues the erase with the cycles it had left. The array contents are modelled: a sector reads a pattern computed from the address until it has been erased.

Writes arrive as a valid/ready stream. `wr_ready` is held high, so the block never back-pressures a write, and a write is taken in any cycle where `wr_valid` is high. Reads have no back-pressure either: a response appears exactly one cycle after the request, and the consumer must take it in that cycle.

Top module: `flash_sector_erase`

## Requirements
- R1: The ordered writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at any address open the acceptance window and select that address's sector. The unlock addresses compare on address bits 10:0, and the sector is the top log2(N_SECT) address bits. In the window `ready`=0 and `tmr_flag`=0.
- R2: A write that does not match the next expected step of the sequence returns the block to array read. A later lone 30 write then has no effect.
- R3: If no write arrives, the window closes WINDOW_CYC clock edges after the last accepted write. The erase phase then starts with `tmr_flag`=1 and `ready`=0.
- R4: A 30 write inside the window adds its sector to the selection and restarts the full window.
- R5: Any other write inside the window, except B0, aborts the operation. The selection is cleared, `ready` returns to 1, and no sector is erased.
- R6: During the erase phase, every write except B0 is ignored.
- R7: A B0 write inside the window enters the suspended state at the next edge.
- R8: A B0 write during the erase phase enters the suspended state SUSP_LAT edges later. Erasing continues during that latency. `suspended`=1 with `ready`=1 and `tmr_flag`=0.
- R9: In the window and erase phases, every read returns a status byte: bit7=0, bit6=toggle, bit3=`tmr_flag`, all other bits 0. The toggle inverts after each such read.
- R10: While suspended, a read of a selected sector returns bit7=1, bit6=the held toggle value, bit3=1, all other bits 0, and the toggle does not change. A read of any other sector returns array data.
- R11: A 30 write while suspended resumes the erase. The erase phase spans ERASE_CYC edges in total, across all suspensions.
- R12: When the erase finishes, `ready` goes to 1 and the selection is released. Array reads return FF in erased sectors and C3 ^ addr[7:0] ^ addr[ADDR_W-1:8] in all other sectors.
- R13: Asserting the asynchronous reset returns the block to array read at once. It drops any window or erase, clears the selection, clears the erased map and clears the toggle.
- R14: `wr_ready` is always 1. `rsp_valid` is high in exactly the cycle after a cycle with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Always 1; writes are never stalled |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Read response present (one cycle after request) |
| rsp_data | output | 8 | Array data or status byte |
| ready | output | 1 | 1 when no window or erase is in progress |
| tmr_flag | output | 1 | 1 once the window has closed and erase runs |
| suspended | output | 1 | 1 while the erase is suspended |

## Verification
The bench builds the block with WINDOW_CYC=8, ERASE_CYC=40 and SUSP_LAT=4, and keeps the default 8 sectors of 512 words. With a window of 8 cycles, the last cycle before expiry and the restart by an added sector fit into a short directed sequence. With the erase much longer than the suspend latency, both the late suspend and the resumed remainder can be observed before completion. The erase-cycle total across a suspension is counted by the reference model. The reset-during-erase case is reachable within a few dozen cycles.

// File: rtl/flash_se_pkg.sv
package flash_se_pkg;

  localparam int unsigned UNLK_W = 11;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_ARM    = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_HOLD   = 8'hB0;

  localparam logic [UNLK_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [UNLK_W-1:0] KEY_ADDR_B = 11'h2AA;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_KEY3,
    ST_KEY4,
    ST_WINDOW,
    ST_ERASE,
    ST_HOLD_WAIT,
    ST_HELD
  } se_state_e;

  typedef struct packed {
    logic key_a;
    logic key_b;
    logic arm;
    logic sector;
    logic hold;
  } wr_kind_t;

endpackage

// File: rtl/se_cmd_decode.sv
module se_cmd_decode
  import flash_se_pkg::*;
(
  input  logic [UNLK_W-1:0] low_addr,
  input  logic [7:0]        data,
  output wr_kind_t          kind
);

  logic at_a;
  logic at_b;

  always_comb begin
    at_a        = (low_addr == KEY_ADDR_A);
    at_b        = (low_addr == KEY_ADDR_B);
    kind.key_a  = at_a && (data == CMD_KEY_A);
    kind.key_b  = at_b && (data == CMD_KEY_B);
    kind.arm    = at_a && (data == CMD_ARM);
    kind.sector = (data == CMD_SECTOR);
    kind.hold   = (data == CMD_HOLD);
  end

endmodule

// File: rtl/se_timers.sv
module se_timers #(
  parameter int unsigned WINDOW_CYC = 50,
  parameter int unsigned ERASE_CYC  = 2000,
  parameter int unsigned SUSP_LAT   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_load,
  input  logic win_run,
  input  logic ers_load,
  input  logic ers_run,
  input  logic lat_load,
  input  logic lat_run,
  output logic win_done,
  output logic ers_done,
  output logic lat_done
);

  localparam int unsigned WIN_W = $clog2(WINDOW_CYC + 1);
  localparam int unsigned ERS_W = $clog2(ERASE_CYC + 1);
  localparam int unsigned LAT_W = $clog2(SUSP_LAT + 1);

  logic [WIN_W-1:0] win_cnt;
  logic [ERS_W-1:0] ers_cnt;
  logic [LAT_W-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      ers_cnt <= '0;
      lat_cnt <= '0;
    end else begin
      if (win_load)     win_cnt <= WIN_W'(WINDOW_CYC);
      else if (win_run) win_cnt <= win_cnt - 1'b1;
      if (ers_load)     ers_cnt <= ERS_W'(ERASE_CYC);
      else if (ers_run) ers_cnt <= ers_cnt - 1'b1;
      if (lat_load)     lat_cnt <= LAT_W'(SUSP_LAT);
      else if (lat_run) lat_cnt <= lat_cnt - 1'b1;
    end
  end

  assign win_done = win_run && (win_cnt == WIN_W'(1));
  assign ers_done = ers_run && (ers_cnt == ERS_W'(1));
  assign lat_done = lat_run && (lat_cnt == LAT_W'(1));

endmodule

// File: rtl/se_sector_buf.sv
module se_sector_buf #(
  parameter int unsigned N_SECT = 8,
  parameter int unsigned SECT_W = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [SECT_W-1:0] add_idx,
  input  logic              drop,
  input  logic              commit,
  output logic [N_SECT-1:0] sel,
  output logic [N_SECT-1:0] erased
);

  for (genvar g = 0; g < N_SECT; g++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[g]    <= 1'b0;
        erased[g] <= 1'b0;
      end else if (commit) begin
        erased[g] <= erased[g] | sel[g];
        sel[g]    <= 1'b0;
      end else if (drop) begin
        sel[g]    <= 1'b0;
      end else if (add_en && (add_idx == SECT_W'(g))) begin
        sel[g]    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/se_read_port.sv
module se_read_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_SECT = 8,
  parameter int unsigned SECT_W = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              tmr_bit,
  input  logic              held,
  input  logic [N_SECT-1:0] sel,
  input  logic [N_SECT-1:0] erased,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);

  logic              tog;
  logic [SECT_W-1:0] rsec;
  logic [7:0]        pick;

  assign rsec = rd_addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (busy)
      pick = {1'b0, tog, 2'b00, tmr_bit, 3'b000};
    else if (held && sel[rsec])
      pick = {1'b1, tog, 2'b00, 1'b1, 3'b000};
    else if (erased[rsec])
      pick = 8'hFF;
    else
      pick = 8'hC3 ^ rd_addr[7:0] ^ 8'(rd_addr >> 8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      tog       <= 1'b0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= pick;
      if (rd_valid && busy) tog <= ~tog;
    end
  end

endmodule

// File: rtl/flash_sector_erase.sv
module flash_sector_erase
  import flash_se_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned N_SECT     = 8,
  parameter int unsigned WINDOW_CYC = 50,
  parameter int unsigned ERASE_CYC  = 2000,
  parameter int unsigned SUSP_LAT   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              ready,
  output logic              tmr_flag,
  output logic              suspended
);

  localparam int unsigned SECT_W = $clog2(N_SECT);

  se_state_e         state, state_nx;
  wr_kind_t          kind;
  logic [N_SECT-1:0] sel, erased;
  logic              win_load, win_run, win_done;
  logic              ers_load, ers_run, ers_done;
  logic              lat_load, lat_run, lat_done;
  logic              add_en, drop, commit;
  logic              busy;

  assign wr_ready = 1'b1;

  se_cmd_decode u_dec (
    .low_addr (wr_addr[UNLK_W-1:0]),
    .data     (wr_data),
    .kind     (kind)
  );

  assign win_run = (state == ST_WINDOW) && !wr_valid;
  assign ers_run = (state == ST_ERASE) || (state == ST_HOLD_WAIT);
  assign lat_run = (state == ST_HOLD_WAIT);

  se_timers #(
    .WINDOW_CYC (WINDOW_CYC),
    .ERASE_CYC  (ERASE_CYC),
    .SUSP_LAT   (SUSP_LAT)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_load (win_load),
    .win_run  (win_run),
    .ers_load (ers_load),
    .ers_run  (ers_run),
    .lat_load (lat_load),
    .lat_run  (lat_run),
    .win_done (win_done),
    .ers_done (ers_done),
    .lat_done (lat_done)
  );

  se_sector_buf #(
    .N_SECT (N_SECT),
    .SECT_W (SECT_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (add_en),
    .add_idx (wr_addr[ADDR_W-1 -: SECT_W]),
    .drop    (drop),
    .commit  (commit),
    .sel     (sel),
    .erased  (erased)
  );

  always_comb begin
    state_nx = state;
    win_load = 1'b0;
    ers_load = 1'b0;
    lat_load = 1'b0;
    add_en   = 1'b0;
    drop     = 1'b0;
    commit   = 1'b0;
    unique case (state)
      ST_ARRAY:  if (wr_valid && kind.key_a) state_nx = ST_KEY1;
      ST_KEY1:   if (wr_valid) state_nx = kind.key_b ? ST_KEY2  : ST_ARRAY;
      ST_KEY2:   if (wr_valid) state_nx = kind.arm   ? ST_ARMED : ST_ARRAY;
      ST_ARMED:  if (wr_valid) state_nx = kind.key_a ? ST_KEY3  : ST_ARRAY;
      ST_KEY3:   if (wr_valid) state_nx = kind.key_b ? ST_KEY4  : ST_ARRAY;
      ST_KEY4: begin
        if (wr_valid) begin
          if (kind.sector) begin
            state_nx = ST_WINDOW;
            add_en   = 1'b1;
            win_load = 1'b1;
          end else begin
            state_nx = ST_ARRAY;
          end
        end
      end
      ST_WINDOW: begin
        if (wr_valid) begin
          if (kind.sector) begin
            add_en   = 1'b1;
            win_load = 1'b1;
          end else if (kind.hold) begin
            state_nx = ST_HELD;
            ers_load = 1'b1;
          end else begin
            state_nx = ST_ARRAY;
            drop     = 1'b1;
          end
        end else if (win_done) begin
          state_nx = ST_ERASE;
          ers_load = 1'b1;
        end
      end
      ST_ERASE: begin
        if (ers_done) begin
          state_nx = ST_ARRAY;
          commit   = 1'b1;
        end else if (wr_valid && kind.hold) begin
          state_nx = ST_HOLD_WAIT;
          lat_load = 1'b1;
        end
      end
      ST_HOLD_WAIT: begin
        if (ers_done) begin
          state_nx = ST_ARRAY;
          commit   = 1'b1;
        end else if (lat_done) begin
          state_nx = ST_HELD;
        end
      end
      ST_HELD:   if (wr_valid && kind.sector) state_nx = ST_ERASE;
      default:   state_nx = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ARRAY;
    else        state <= state_nx;
  end

  assign busy      = (state == ST_WINDOW) || ers_run;
  assign ready     = !busy;
  assign tmr_flag  = ers_run;
  assign suspended = (state == ST_HELD);

  se_read_port #(
    .ADDR_W (ADDR_W),
    .N_SECT (N_SECT),
    .SECT_W (SECT_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .tmr_bit   (ers_run),
    .held      (suspended),
    .sel       (sel),
    .erased    (erased),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/flash_sector_erase_chk.sv
module flash_sector_erase_chk #(
  parameter int unsigned N_SECT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [7:0]        wr_data,
  input logic              rd_valid,
  input logic              rsp_valid,
  input logic              ready,
  input logic              tmr_flag,
  input logic              suspended,
  input logic [N_SECT-1:0] sel_mask
);

  a_r3_timer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_flag |-> !ready);

  a_r8_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (ready && !tmr_flag));

  a_r7_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data == 8'hB0 && !ready && !tmr_flag) |=> suspended);

  a_r6_erase_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && wr_valid && wr_data != 8'hB0) |=> (tmr_flag || ready));

  a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready || suspended) |-> (sel_mask != '0));

  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !suspended) |-> (sel_mask == '0));

  a_r14_rsp_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  a_r14_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

endmodule

bind flash_sector_erase flash_sector_erase_chk #(.N_SECT(N_SECT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .rd_valid  (rd_valid),
  .rsp_valid (rsp_valid),
  .ready     (ready),
  .tmr_flag  (tmr_flag),
  .suspended (suspended),
  .sel_mask  (sel)
);

// File: tb/flash_sector_erase_tb.sv
module flash_sector_erase_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int WC  = 8;
  localparam int EC  = 40;
  localparam int SL  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic          ready, tmr_flag, suspended;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sector_erase #(
    .ADDR_W(AW), .N_SECT(8), .WINDOW_CYC(WC), .ERASE_CYC(EC), .SUSP_LAT(SL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ready(ready),
    .tmr_flag(tmr_flag), .suspended(suspended)
  );

  // reference model: md 0 array, 1..5 sequence steps, 6 window, 7 erase,
  // 8 suspend latency, 9 suspended
  int         md, wcnt, ecnt, lcnt, ers_edges;
  logic [7:0] msel, mers;
  bit         mtog, m_rv;
  logic [7:0] m_rd;

  function automatic logic [7:0] arr(logic [AW-1:0] a, logic [7:0] e);
    if (e[a[11:9]]) return 8'hFF;
    return 8'hC3 ^ a[7:0] ^ {4'h0, a[11:8]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = 0; wcnt = 0; ecnt = 0; lcnt = 0;
      msel = '0; mers = '0; mtog = 1'b0; m_rv = 1'b0; m_rd = '0;
    end else begin
      m_rv = rd_valid;
      if (rd_valid) begin
        if (md >= 6 && md <= 8) begin
          m_rd = {1'b0, mtog, 2'b00, (md >= 7), 3'b000};
          mtog = !mtog;
        end else if (md == 9 && msel[rd_addr[11:9]])
          m_rd = {1'b1, mtog, 2'b00, 1'b1, 3'b000};
        else
          m_rd = arr(rd_addr, mers);
      end
      if (md == 7 || md == 8) ers_edges++;
      case (md)
        0: if (wr_valid && wr_addr[10:0] == 11'h555 && wr_data == 8'hAA) md = 1;
        1: if (wr_valid) md = (wr_addr[10:0] == 11'h2AA && wr_data == 8'h55) ? 2 : 0;
        2: if (wr_valid) md = (wr_addr[10:0] == 11'h555 && wr_data == 8'h80) ? 3 : 0;
        3: if (wr_valid) md = (wr_addr[10:0] == 11'h555 && wr_data == 8'hAA) ? 4 : 0;
        4: if (wr_valid) md = (wr_addr[10:0] == 11'h2AA && wr_data == 8'h55) ? 5 : 0;
        5: if (wr_valid) begin
             if (wr_data == 8'h30) begin md = 6; msel[wr_addr[11:9]] = 1'b1; wcnt = WC; end
             else md = 0;
           end
        6: if (wr_valid) begin
             if (wr_data == 8'h30) begin msel[wr_addr[11:9]] = 1'b1; wcnt = WC; end
             else if (wr_data == 8'hB0) begin md = 9; ecnt = EC; end
             else begin md = 0; msel = '0; end
           end else if (wcnt == 1) begin md = 7; ecnt = EC; end
           else wcnt--;
        7: if (ecnt == 1) begin md = 0; mers |= msel; msel = '0; end
           else begin
             ecnt--;
             if (wr_valid && wr_data == 8'hB0) begin md = 8; lcnt = SL; end
           end
        8: if (ecnt == 1) begin md = 0; mers |= msel; msel = '0; end
           else begin
             ecnt--;
             if (lcnt == 1) md = 9; else lcnt--;
           end
        9: if (wr_valid && wr_data == 8'h30) md = 7;
        default: md = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R1 ready vs model", {7'b0, ready}, {7'b0, !(md >= 6 && md <= 8)});
      chk("R3 tmr_flag vs model", {7'b0, tmr_flag}, {7'b0, (md == 7 || md == 8)});
      chk("R8 suspended vs model", {7'b0, suspended}, {7'b0, (md == 9)});
      chk("R14 rsp_valid vs model", {7'b0, rsp_valid}, {7'b0, m_rv});
      if (m_rv) chk("R9 rsp_data vs model", rsp_data, m_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic seq(input logic [AW-1:0] a);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, 8'h30);
  endtask

  task automatic wait_ready;
    for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(1);
    // R13 reset state, R14 stream rules
    chk("R13 ready after reset", {7'b0, ready}, 8'd1);
    chk("R13 tmr after reset", {7'b0, tmr_flag}, 8'd0);
    chk("R14 wr_ready", {7'b0, wr_ready}, 8'd1);
    rd(12'h100);
    chk("R14 rsp_valid", {7'b0, rsp_valid}, 8'd1);
    chk("R12 array read", rsp_data, 8'hC2);

    // R2 broken sequence
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wr(12'h600, 8'h30);
    chk("R2 no window", {7'b0, ready}, 8'd1);

    // R1 window, R9 status reads
    seq(12'h600);
    chk("R1 ready low", {7'b0, ready}, 8'd0);
    chk("R1 tmr low", {7'b0, tmr_flag}, 8'd0);
    rd(12'h000);
    chk("R9 first status", rsp_data, 8'h00);
    rd(12'h000);
    chk("R9 toggled status", rsp_data, 8'h40);
    // R4 add sector and restart, R3 expiry
    wr(12'hA00, 8'h30);
    ers_edges = 0;
    idle(WC - 1);
    chk("R4 window restarted", {7'b0, tmr_flag}, 8'd0);
    idle(1);
    chk("R3 erase started", {7'b0, tmr_flag}, 8'd1);
    // R6 ignored write
    wr(12'h555, 8'hAA);
    chk("R6 still erasing", {7'b0, tmr_flag}, 8'd1);
    // R8 latency
    wr(12'h000, 8'hB0);
    idle(SL - 1);
    chk("R8 not yet held", {7'b0, suspended}, 8'd0);
    idle(1);
    chk("R8 held", {7'b0, suspended}, 8'd1);
    // R10 reads while held
    rd(12'h600);
    chk("R10 selected status", rsp_data, 8'h88);
    rd(12'hA10);
    chk("R10 second selected", rsp_data, 8'h88);
    rd(12'h010);
    chk("R10 other sector array", rsp_data, 8'hD3);
    // R11 resume
    wr(12'h123, 8'h30);
    chk("R11 resumed", {7'b0, tmr_flag}, 8'd1);
    wait_ready();
    chk("R11 total erase edges", 8'(ers_edges), 8'(EC));
    rd(12'h600);
    chk("R12 sector 3 erased", rsp_data, 8'hFF);
    rd(12'hA00);
    chk("R12 sector 5 erased", rsp_data, 8'hFF);
    rd(12'h000);
    chk("R12 sector 0 intact", rsp_data, 8'hC3);

    // R5 abort
    seq(12'h200);
    wr(12'h555, 8'hF0);
    chk("R5 aborted ready", {7'b0, ready}, 8'd1);
    idle(WC + 2);
    chk("R5 no erase", {7'b0, tmr_flag}, 8'd0);
    rd(12'h200);
    chk("R5 sector 1 intact", rsp_data, 8'hC1);

    // R7 hold inside window
    seq(12'hC00);
    wr(12'h3FF, 8'hB0);
    chk("R7 held at once", {7'b0, suspended}, 8'd1);
    rd(12'hC00);
    chk("R10 held from window", rsp_data, 8'h88);
    wr(12'h000, 8'h30);
    wait_ready();
    rd(12'hC00);
    chk("R12 sector 6 erased", rsp_data, 8'hFF);

    // R13 reset during erase
    seq(12'hE00);
    idle(WC + 1);
    chk("R13 erasing before reset", {7'b0, tmr_flag}, 8'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    chk("R13 ready in reset", {7'b0, ready}, 8'd1);
    rst_n = 1'b1;
    idle(1);
    chk("R13 tmr after reset", {7'b0, tmr_flag}, 8'd0);
    rd(12'hE00);
    chk("R13 sector 7 intact", rsp_data, 8'hCD);
    rd(12'h600);
    chk("R13 erased map cleared", rsp_data, 8'hC5);

    idle(3);
    summary();
  end

endmodule